// File: doc/BRIEF.md
# Dual Message Buffer Register Port

This block holds two 64-byte message buffers, numbered 0 and 1. They sit between a byte-wide host register port and a data-link controller, and the controller is seen here only as a byte-stream handshake. Each buffer has one data window address. The host streams a whole message through that window, because every access moves the buffer's own byte pointer on by one. Each buffer has a transmit bank and a receive bank. A host write to a window goes into the transmit bank and a host read comes from the receive bank, so transmit data can never be read back.

On the transmit side the host fills the buffer that the transmit count register names as free, then writes the message length to that register. The buffer is then committed, handed to the controller and sent whole. The free indicator then moves to the other buffer. On the receive side the controller stores each incoming message in a buffer that is not held and raises an end-of-message interrupt. The receive count register tells the host which buffer to read and how many bytes it holds. The host then acknowledges the interrupt, reads the bytes, and releases the buffer.

Top module: `msgbuf_port`

## Requirements
- R1: After reset all buffer bytes are 0x00, `irq` and `tx_valid` are low, and the transmit count (address 2), receive count (address 3) and status (address 4) registers all read 0x00.
- R2: Each write or read of window 0 (address 0) or window 1 (address 1) moves that buffer's byte pointer up by one. Once the pointer reaches byte 63 it stays there, so further accesses hit byte 63.
- R3: A write of a count from 1 to 64 in bits [6:0] of the transmit count register commits the buffer named by that register's bit 7, clears that buffer's pointer to 0 and toggles bit 7. The write is ignored if the count is 0 or above 64, or if bit 6 (free buffer still pending transmission) is set.
- R4: Committed buffers are sent in commit order. Each sends bytes 0 up to length-1, and `tx_last` marks the final byte. `tx_data` and `tx_last` hold steady while `tx_valid` is high and `tx_ready` is low. Bit 6 clears once the buffer has been sent.
- R5: A host write to the window of a committed buffer leaves that buffer's transmit data unchanged.
- R6: A window read returns receive-bank data and never the transmit bytes loaded by the host.
- R7: A received message goes into a buffer that is not held. The preferred buffer alternates and starts at 0. On the last byte, status bit 0 and `irq` rise. The receive count register then shows the buffer in bit 7 and the byte count (1 to 64) in bits [6:0]. Bytes beyond the 64th are dropped.
- R8: Writing status with bit 0 set clears the interrupt and resets the pointer of the buffer named in receive count bit 7. A message ending in the same cycle keeps the interrupt set.
- R9: A write to the receive count register releases the named buffer. When both buffers are held, bit 7 names the older one first. With nothing held, bits [6:0] read 0.
- R10: A message that starts while both buffers are held is dropped, and stored messages stay intact. Status bit 1 is then set and stays set until status is written with bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register select: 0/1 windows, 2 transmit count, 3 receive count, 4 status |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe; advances a window pointer |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the selected register, combinational |
| irq | output | 1 | Receive end-of-message interrupt (status bit 0) |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the final byte of a message |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Marks the final byte of a transmit message |
| tx_ready | input | 1 | Controller accepts the transmit byte |

## Verification
The assertions check on every cycle that the pointers step and saturate, that the free indicator toggles on each commit, and that the transmit byte holds steady under backpressure. They also check that the interrupt only rises after a completed message, that the ready pointer always names a held buffer, and that a message arriving with both buffers held sets the overrun flag. Only the bench's scenarios can show the rest: the actual bytes a message carries end to end, which commits are rejected, the receive ordering and the truncation at 64 bytes. The same goes for the separation of the transmit and receive banks, and the case of an interrupt being set and cleared in the same cycle.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;
  localparam int NBUF = 2;

  localparam logic [2:0] ADDR_WIN0  = 3'd0;
  localparam logic [2:0] ADDR_WIN1  = 3'd1;
  localparam logic [2:0] ADDR_TXCNT = 3'd2;
  localparam logic [2:0] ADDR_RXCNT = 3'd3;
  localparam logic [2:0] ADDR_STAT  = 3'd4;

  // Saturating pointer step: never goes above lim.
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // A transmit length is legal when it is 1..lim bytes.
  function automatic logic count_ok(int unsigned c, int unsigned lim);
    return (c >= 1) && (c <= lim);
  endfunction
endpackage

// File: rtl/msgbuf_hostptr.sv
module msgbuf_hostptr
  import msgbuf_pkg::*;
#(
  parameter int BYTES = 64,
  localparam int PW = $clog2(BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] adv,
  input  logic [NBUF-1:0] clr,
  output logic [PW-1:0]   ptr [NBUF]
);
  for (genvar i = 0; i < NBUF; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n)      ptr[i] <= '0;
      else if (clr[i]) ptr[i] <= '0;
      else if (adv[i]) ptr[i] <= PW'(sat_inc(32'(ptr[i]), BYTES - 1));
    end
  end
endmodule

// File: rtl/msgbuf_tx.sv
module msgbuf_tx
  import msgbuf_pkg::*;
#(
  parameter int BYTES = 64,
  parameter int DW    = 8,
  localparam int PW = $clog2(BYTES),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_buf,
  input  logic [PW-1:0] wr_ptr,
  input  logic [DW-1:0] wr_data,
  input  logic          commit_req,
  input  logic [DW-2:0] commit_len,
  input  logic          tx_ready,
  output logic          free_buf,
  output logic          pending,
  output logic          commit_ok,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic          tx_done
);
  logic [DW-1:0]   mem [NBUF][BYTES];
  logic [NBUF-1:0] committed;
  logic [CW-1:0]   len [NBUF];
  logic            load_sel, send_sel;
  logic [PW-1:0]   send_idx;

  assign commit_ok = commit_req && count_ok(32'(commit_len), BYTES) && !committed[load_sel];
  assign free_buf  = load_sel;
  assign pending   = committed[load_sel];
  assign tx_valid  = committed[send_sel];
  assign tx_data   = mem[send_sel][send_idx];
  assign tx_last   = (CW'(send_idx) + CW'(1)) == len[send_sel];
  assign tx_done   = tx_valid && tx_ready && tx_last;

  for (genvar b = 0; b < NBUF; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < BYTES; k++) mem[b][k] <= '0;
      end else if (wr_en && wr_buf == 1'(b) && !committed[b]) begin
        mem[b][wr_ptr] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      committed <= '0;
      load_sel  <= 1'b0;
      send_sel  <= 1'b0;
      send_idx  <= '0;
      for (int k = 0; k < NBUF; k++) len[k] <= '0;
    end else begin
      if (commit_ok) begin
        committed[load_sel] <= 1'b1;
        len[load_sel]       <= CW'(commit_len);
        load_sel            <= ~load_sel;
      end
      if (tx_valid && tx_ready) begin
        if (tx_last) begin
          committed[send_sel] <= 1'b0;
          send_idx            <= '0;
          send_sel            <= ~send_sel;
        end else begin
          send_idx <= send_idx + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/msgbuf_rx.sv
module msgbuf_rx
  import msgbuf_pkg::*;
#(
  parameter int BYTES = 64,
  parameter int DW    = 8,
  localparam int PW = $clog2(BYTES),
  localparam int CW = PW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  input  logic [DW-1:0]   rx_data,
  input  logic            rx_last,
  input  logic            rd_buf,
  input  logic [PW-1:0]   rd_ptr,
  input  logic            release_req,
  input  logic            ack_eot,
  input  logic            clr_ovr,
  output logic [DW-1:0]   rd_data,
  output logic            ready_buf,
  output logic [CW-1:0]   ready_len,
  output logic            eot,
  output logic            ovr,
  output logic [NBUF-1:0] held,
  output logic            msg_start,
  output logic            msg_done,
  output logic            both_held
);
  logic [DW-1:0] mem [NBUF][BYTES];
  logic [CW-1:0] len [NBUF];
  logic          busy, cur, drop, pref;
  logic [CW-1:0] cnt;

  logic            sel, dropping, wr_ok;
  logic [CW-1:0]   base, cnt_new;
  logic [NBUF-1:0] held_n;
  logic            rdy_n;

  always_comb begin
    both_held = &held;
    msg_start = rx_valid && !busy;
    sel       = busy ? cur : (!held[pref] ? pref : ~pref);
    dropping  = busy ? drop : both_held;
    base      = busy ? cnt : '0;
    wr_ok     = rx_valid && !dropping && (base < CW'(BYTES));
    cnt_new   = base + (wr_ok ? CW'(1) : CW'(0));
    msg_done  = rx_valid && rx_last && !dropping;
    held_n    = held;
    rdy_n     = ready_buf;
    if (release_req && held[ready_buf]) begin
      held_n[ready_buf] = 1'b0;
      rdy_n             = ~ready_buf;
    end
    if (msg_done) begin
      if (!held_n[~sel]) rdy_n = sel;
      held_n[sel] = 1'b1;
    end
  end

  assign rd_data   = mem[rd_buf][rd_ptr];
  assign ready_len = held[ready_buf] ? len[ready_buf] : '0;

  for (genvar b = 0; b < NBUF; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < BYTES; k++) mem[b][k] <= '0;
        len[b] <= '0;
      end else begin
        if (wr_ok && sel == 1'(b)) mem[b][base[PW-1:0]] <= rx_data;
        if (msg_done && sel == 1'(b)) len[b] <= cnt_new;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0; ready_buf <= 1'b0; busy <= 1'b0; cur <= 1'b0;
      drop <= 1'b0; pref <= 1'b0; cnt <= '0; eot <= 1'b0; ovr <= 1'b0;
    end else begin
      held      <= held_n;
      ready_buf <= rdy_n;
      if (rx_valid) begin
        busy <= !rx_last;
        cur  <= sel;
        drop <= dropping;
        cnt  <= cnt_new;
      end
      if (msg_done) pref <= ~sel;
      if (msg_done)     eot <= 1'b1;
      else if (ack_eot) eot <= 1'b0;
      if (msg_start && both_held) ovr <= 1'b1;
      else if (clr_ovr)           ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/msgbuf_port.sv
module msgbuf_port
  import msgbuf_pkg::*;
#(
  parameter int BYTES = 64,
  parameter int DW    = 8,
  parameter int AW    = 3,
  localparam int PW = $clog2(BYTES),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          irq,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_last,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  input  logic          tx_ready
);
  logic [PW-1:0]   host_ptr [NBUF];
  logic [NBUF-1:0] ptr_adv, ptr_clr;
  logic            win_hit, win_sel, ack_eot, commit_ok, tx_done;
  logic            free_buf, pending, ready_buf, eot, ovr;
  logic            msg_start, msg_done, both_held;
  logic [NBUF-1:0] held;
  logic [CW-1:0]   ready_len;
  logic [DW-1:0]   rx_rd_data;

  assign win_hit = (host_addr == AW'(ADDR_WIN0)) || (host_addr == AW'(ADDR_WIN1));
  assign win_sel = host_addr[0];
  assign ack_eot = host_wr && host_addr == AW'(ADDR_STAT) && host_wdata[0];

  for (genvar i = 0; i < NBUF; i++) begin : g_ctl
    assign ptr_adv[i] = (host_wr || host_rd) && win_hit && win_sel == 1'(i);
    assign ptr_clr[i] = (commit_ok && free_buf == 1'(i)) || (ack_eot && ready_buf == 1'(i));
  end

  msgbuf_hostptr #(.BYTES(BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(ptr_adv), .clr(ptr_clr), .ptr(host_ptr)
  );

  msgbuf_tx #(.BYTES(BYTES), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr && win_hit), .wr_buf(win_sel), .wr_ptr(host_ptr[win_sel]),
    .wr_data(host_wdata),
    .commit_req(host_wr && host_addr == AW'(ADDR_TXCNT)),
    .commit_len(host_wdata[DW-2:0]), .tx_ready(tx_ready),
    .free_buf(free_buf), .pending(pending), .commit_ok(commit_ok),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_done(tx_done)
  );

  msgbuf_rx #(.BYTES(BYTES), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rd_buf(win_sel), .rd_ptr(host_ptr[win_sel]),
    .release_req(host_wr && host_addr == AW'(ADDR_RXCNT)),
    .ack_eot(ack_eot),
    .clr_ovr(host_wr && host_addr == AW'(ADDR_STAT) && host_wdata[1]),
    .rd_data(rx_rd_data), .ready_buf(ready_buf), .ready_len(ready_len),
    .eot(eot), .ovr(ovr), .held(held),
    .msg_start(msg_start), .msg_done(msg_done), .both_held(both_held)
  );

  assign irq = eot;

  always_comb begin
    host_rdata = '0;
    if (win_hit)                              host_rdata = rx_rd_data;
    else if (host_addr == AW'(ADDR_TXCNT))    host_rdata = {free_buf, pending, (DW-2)'(0)};
    else if (host_addr == AW'(ADDR_RXCNT))    host_rdata = {ready_buf, (DW-1)'(ready_len)};
    else if (host_addr == AW'(ADDR_STAT))     host_rdata = {(DW-2)'(0), ovr, eot};
  end
endmodule

// File: rtl/msgbuf_port_chk.sv
module msgbuf_port_chk #(
  parameter int BYTES = 64,
  localparam int PW = $clog2(BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] ptr0,
  input logic          adv0,
  input logic          clr0,
  input logic          commit_ok,
  input logic          free_buf,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          irq,
  input logic          msg_done,
  input logic          msg_start,
  input logic          both_held,
  input logic          ovr,
  input logic [1:0]    held,
  input logic          ready_buf
);
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv0 && !clr0 && ptr0 != PW'(BYTES - 1) |=> ptr0 == $past(ptr0) + PW'(1));

  a_r2_ptr_sat: assert property (@(posedge clk) disable iff (!rst_n)
    adv0 && !clr0 && ptr0 == PW'(BYTES - 1) |=> ptr0 == PW'(BYTES - 1));

  a_r3_free_flip: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |=> free_buf != $past(free_buf));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r7_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> irq);

  a_r7_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(msg_done));

  a_r9_rdy_held: assert property (@(posedge clk) disable iff (!rst_n)
    held != 2'b00 |-> held[ready_buf]);

  a_r10_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start && both_held |=> ovr);
endmodule

bind msgbuf_port msgbuf_port_chk #(.BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr0(host_ptr[0]), .adv0(ptr_adv[0]), .clr0(ptr_clr[0]),
  .commit_ok(commit_ok), .free_buf(free_buf), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .irq(irq), .msg_done(msg_done),
  .msg_start(msg_start), .both_held(both_held), .ovr(ovr), .held(held),
  .ready_buf(ready_buf)
);

// File: tb/msgbuf_port_bench.sv
module msgbuf_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq;
  logic       rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_valid, tx_last;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msgbuf_port u_msgbuf_port (.*);

  // {write, addr, data, expected read}
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd2, 8'h00, 8'h00},
    {1'b1, 3'd2, 8'h00, 8'h00},
    {1'b1, 3'd2, 8'h41, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h00},
    {1'b1, 3'd0, 8'hA0, 8'h00},
    {1'b1, 3'd0, 8'hA1, 8'h00},
    {1'b1, 3'd0, 8'hA2, 8'h00},
    {1'b1, 3'd2, 8'h03, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h80},
    {1'b1, 3'd0, 8'hEE, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b1, 3'd1, 8'hB0, 8'h00},
    {1'b1, 3'd1, 8'hB1, 8'h00},
    {1'b1, 3'd2, 8'h02, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h40},
    {1'b1, 3'd2, 8'h01, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h40},
    {1'b0, 3'd4, 8'h00, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h40}
  };

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string what);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  task automatic rx_msg(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = base + 8'(i); rx_last = (i == n - 1);
      @(posedge clk); #1;
    end
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp_tx [5] = '{8'hA0, 8'hA1, 8'hA2, 8'hB0, 8'hB1};
    int idx, cyc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk({7'd0, irq}, 8'h00, "R1 irq after reset");
    chk({7'd0, tx_valid}, 8'h00, "R1 tx_valid after reset");
    rd(3'd3, d); chk(d, 8'h00, "R1 receive count after reset");

    // Table: loads, commits, rejected commits, bank separation (R2 R3 R5 R6)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][18:16], d);
        chk(d, VEC[i][7:0], $sformatf("R3/R6 table row %0d", i));
      end
    end

    // R4 drain with backpressure; R5 EE write must not appear
    idx = 0; cyc = 0;
    while (idx < 5 && cyc < 60) begin
      tx_ready = (cyc % 3) != 1;
      #1;
      if (tx_valid) begin
        chk(tx_data, exp_tx[idx], "R4/R5 transmit byte");
        chk({7'd0, tx_last}, {7'd0, idx == 2 || idx == 4}, "R4 tx_last");
        if (tx_ready) idx++;
      end
      @(posedge clk); #1; cyc++;
    end
    tx_ready = 1'b0;
    chk(8'(idx), 8'd5, "R4 bytes sent");
    chk({7'd0, tx_valid}, 8'h00, "R4 idle after drain");
    rd(3'd2, d); chk(d, 8'h00, "R4 pending cleared");

    // R7 first message to buffer 0
    rx_msg(3, 8'h10);
    chk({7'd0, irq}, 8'h01, "R7 irq raised");
    rd(3'd3, d); chk(d, 8'h03, "R7 receive count buf0");
    wr(3'd4, 8'h01);
    chk({7'd0, irq}, 8'h00, "R8 irq cleared");
    for (int i = 0; i < 3; i++) begin
      rd(3'd0, d); chk(d, 8'h10 + 8'(i), "R2/R8 read buf0 from byte 0");
    end

    // R9 second message to buffer 1, older shown first
    rx_msg(5, 8'h20);
    rd(3'd3, d); chk(d, 8'h03, "R9 older buffer first");
    rd(3'd4, d); chk(d, 8'h01, "R7 status after second message");

    // R10 overrun
    rx_msg(2, 8'h55);
    rd(3'd4, d); chk(d, 8'h03, "R10 overrun set");
    wr(3'd4, 8'h02);
    rd(3'd4, d); chk(d, 8'h01, "R10 overrun cleared");
    wr(3'd3, 8'h00);
    rd(3'd3, d); chk(d, 8'h85, "R9 after release buf1 ready");
    wr(3'd4, 8'h01);
    for (int i = 0; i < 5; i++) begin
      rd(3'd1, d); chk(d, 8'h20 + 8'(i), "R10 stored message intact");
    end
    wr(3'd3, 8'h00);
    rd(3'd3, d); chk(d, 8'h00, "R9 none held");

    // R7 truncation at 64 bytes, R2 saturation
    rx_msg(70, 8'h00);
    rd(3'd3, d); chk(d, 8'h40, "R7 count saturates at 64");
    wr(3'd4, 8'h01);
    for (int i = 0; i < 64; i++) begin
      rd(3'd0, d); chk(d, 8'(i), "R7 long message byte");
    end
    rd(3'd0, d); chk(d, 8'h3F, "R2 pointer saturates at 63");
    rd(3'd0, d); chk(d, 8'h3F, "R2 pointer stays at 63");

    // R8 set wins over clear in the same cycle
    fork
      rx_msg(1, 8'h90);
      wr(3'd4, 8'h01);
    join
    chk({7'd0, irq}, 8'h01, "R8 set wins over clear");
    rd(3'd3, d); chk(d, 8'h40, "R9 buf0 still ready");

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule